// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block puts a small microcontroller core into one of four low-power states and brings it back out. While the core is running, a sleep request strobe, qualified by a sleep-enable bit, picks a target state from a 3-bit mode code. Each sleep state switches off its own subset of the CPU, flash, I/O, ADC and asynchronous-timer clock enables. The two deepest states also assert a stop signal for the main oscillator.

While asleep, the block watches eight wake request lines and keeps only those that the current state allows. The level-sensitive external interrupt group must stay high for a minimum number of cycles before it counts in the oscillator-stopping states. A wake from Idle or ADC noise reduction returns to running on the next edge. A wake from Power-down or Power-save first passes through a start-up state, in which the clocks stay gated for a programmable number of cycles while the oscillator settles. Entering Idle or ADC noise reduction with the ADC enabled emits a one-cycle conversion start pulse.

States and their `state_o` codes:

| State | Code |
|---|---|
| RUN | 0 |
| IDLE | 1 |
| ADCNR | 2 |
| PDOWN | 3 |
| PSAVE | 4 |
| START | 5 |

Transitions:

| From | To | Condition |
|---|---|---|
| RUN | IDLE, ADCNR, PDOWN or PSAVE | An accepted strobe |
| IDLE, ADCNR | RUN | A masked wake |
| PDOWN, PSAVE | START | A masked wake |
| START | RUN | The start-up count expires |

Top module: `slp_clkgate_ctrl`

## Requirements
- R1: After reset the state is RUN (code 0), all five clock enables are 1, and `osc_stop` and `adc_start` are 0.
- R2: In RUN, a `sleep_req` with `sleep_en`=1 moves to the state chosen by `mode` on the next edge. The mode codes are 0 = IDLE, 1 = ADCNR, 2 = PDOWN and 3 = PSAVE; the `state_o` codes are those in the table above.
- R3: A `sleep_req` with `sleep_en`=0, or with a `mode` from 4 to 7, is ignored: the state stays RUN and all clocks stay on. Strobes outside RUN have no effect.
- R4: The outputs per state, as {cpu, flash, io, adc, asy, osc_stop}, are:

| State | Outputs |
|---|---|
| RUN | 111110 |
| IDLE | 001110 |
| ADCNR | 000110 |
| PDOWN | 000001 |
| PSAVE | 000011 |
| START | 0000k0 |

  In START, k is 1 only when START was entered from PSAVE.
- R5: The `wake_req` bits are: 0 = any other enabled interrupt, 1 = reset class, 2 = serial address match, 3 = edge/level external group, 4 = level-only external group, 5 = ADC done, 6 = timer-0 interrupt, 7 = memory ready. In IDLE, any of the eight bits returns to RUN on the next edge.
- R6: In ADCNR, bits 1 to 7 return to RUN on the next edge, and bit 0 is ignored.
- R7: In PDOWN, bits 1 to 4 wake (bit 4 only as qualified by R9), and bits 0, 5, 6 and 7 are ignored.
- R8: In PSAVE, the PDOWN set applies. Bit 6 also wakes, but only when `t0_async`, `t0_irq_en` and `gie` are all 1.
- R9: In PDOWN or PSAVE, bit 4 wakes only on its LVL_HOLD-th consecutive high cycle (LVL_HOLD defaults to 4). A shorter pulse is ignored.
- R10: A wake in PDOWN or PSAVE enters START, which lasts `startup_cnt`+1 cycles and then gives RUN.
- R11: `adc_start` is high for exactly the first cycle of IDLE or ADCNR when `adc_en` was 1 with the accepted strobe. It is never high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_en | input | 1 | Allows sleep strobes |
| sleep_req | input | 1 | Sleep instruction strobe |
| mode | input | 3 | Target sleep mode code |
| adc_en | input | 1 | ADC enabled, for the auto-start |
| t0_async | input | 1 | Timer 0 runs from the asynchronous clock |
| t0_irq_en | input | 1 | Timer 0 interrupt enable |
| gie | input | 1 | Global interrupt enable |
| wake_req | input | 8 | Wake request lines, bit map in R5 |
| startup_cnt | input | CNT_W | Oscillator start-up cycles |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| asy_clk_en | output | 1 | Asynchronous timer clock enable |
| osc_stop | output | 1 | Main oscillator stop |
| adc_start | output | 1 | ADC conversion start pulse |
| state_o | output | 3 | Current state code |

## Verification
Every result here is registered: `state_o`, the clock enables and `adc_start` change at the first rising edge after the inputs that cause them. The bench therefore drives inputs on the falling edge and compares all outputs on the following falling edge against a cycle model updated with those same inputs. Directed checks take their sample 2 ns after the rising edge that should carry the change. For the timed corners the bench counts edges itself: the LVL_HOLD-th high cycle of the level wake, and the `startup_cnt`+1 cycles of START.

// File: rtl/slp_pkg.sv
package slp_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_ADCNR = 3'd2,
        ST_PDOWN = 3'd3,
        ST_PSAVE = 3'd4,
        ST_START = 3'd5
    } slp_state_e;

    localparam int WAKE_W  = 8;
    localparam int WK_ANY  = 0;
    localparam int WK_RST  = 1;
    localparam int WK_ADDR = 2;
    localparam int WK_EXTE = 3;
    localparam int WK_EXTL = 4;
    localparam int WK_ADC  = 5;
    localparam int WK_T0   = 6;
    localparam int WK_NVM  = 7;

    localparam logic [WAKE_W-1:0] MASK_IDLE  = '1;
    localparam logic [WAKE_W-1:0] MASK_ADCNR = ~(WAKE_W'(1) << WK_ANY);
    localparam logic [WAKE_W-1:0] MASK_DEEP  = (WAKE_W'(1) << WK_RST) | (WAKE_W'(1) << WK_ADDR)
                                             | (WAKE_W'(1) << WK_EXTE) | (WAKE_W'(1) << WK_EXTL);
    localparam logic [WAKE_W-1:0] MASK_T0    = WAKE_W'(1) << WK_T0;

    localparam logic [2:0] MD_IDLE  = 3'd0;
    localparam logic [2:0] MD_ADCNR = 3'd1;
    localparam logic [2:0] MD_PDOWN = 3'd2;
    localparam logic [2:0] MD_PSAVE = 3'd3;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic asy;
        logic osc_stop;
    } clk_ctl_t;
endpackage

// File: rtl/slp_wake_mask.sv
module slp_wake_mask
    import slp_pkg::*;
#(
    parameter int LVL_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slp_state_e        state,
    input  logic [WAKE_W-1:0] wake_req,
    input  logic              t0_async,
    input  logic              t0_irq_en,
    input  logic              gie,
    output logic              wake_hit
);
    localparam int LVL_W = (LVL_HOLD < 2) ? 1 : $clog2(LVL_HOLD);
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(LVL_HOLD - 1);

    logic              deep;
    logic              lvl_ok;
    logic [LVL_W-1:0]  lvl_cnt;
    logic [WAKE_W-1:0] qual;
    logic [WAKE_W-1:0] mask;

    assign deep = (state == ST_PDOWN) || (state == ST_PSAVE);

    // Consecutive-high counter for the level-only group in deep states
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_cnt <= '0;
        end else if (deep && wake_req[WK_EXTL]) begin
            if (lvl_cnt != LVL_MAX) lvl_cnt <= lvl_cnt + 1'b1;
        end else begin
            lvl_cnt <= '0;
        end
    end

    assign lvl_ok = wake_req[WK_EXTL] && (lvl_cnt == LVL_MAX);

    for (genvar b = 0; b < WAKE_W; b++) begin : g_qual
        if (b == WK_EXTL) begin : g_lvl
            assign qual[b] = deep ? lvl_ok : wake_req[b];
        end else begin : g_plain
            assign qual[b] = wake_req[b];
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  mask = MASK_IDLE;
            ST_ADCNR: mask = MASK_ADCNR;
            ST_PDOWN: mask = MASK_DEEP;
            ST_PSAVE: mask = MASK_DEEP | ((t0_async && t0_irq_en && gie) ? MASK_T0 : '0);
            default:  mask = '0;
        endcase
    end

    assign wake_hit = |(qual & mask);
endmodule

// File: rtl/slp_start_timer.sv
module slp_start_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             active,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (active && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/slp_clk_decode.sv
module slp_clk_decode
    import slp_pkg::*;
(
    input  slp_state_e state,
    input  logic       keep_asy,
    output clk_ctl_t   ctl
);
    always_comb begin
        unique case (state)
            ST_RUN:   ctl = '{cpu:1'b1, flash:1'b1, io:1'b1, adc:1'b1, asy:1'b1, osc_stop:1'b0};
            ST_IDLE:  ctl = '{cpu:1'b0, flash:1'b0, io:1'b1, adc:1'b1, asy:1'b1, osc_stop:1'b0};
            ST_ADCNR: ctl = '{cpu:1'b0, flash:1'b0, io:1'b0, adc:1'b1, asy:1'b1, osc_stop:1'b0};
            ST_PDOWN: ctl = '{cpu:1'b0, flash:1'b0, io:1'b0, adc:1'b0, asy:1'b0, osc_stop:1'b1};
            ST_PSAVE: ctl = '{cpu:1'b0, flash:1'b0, io:1'b0, adc:1'b0, asy:1'b1, osc_stop:1'b1};
            ST_START: ctl = '{cpu:1'b0, flash:1'b0, io:1'b0, adc:1'b0, asy:keep_asy, osc_stop:1'b0};
            default:  ctl = '{cpu:1'b1, flash:1'b1, io:1'b1, adc:1'b1, asy:1'b1, osc_stop:1'b0};
        endcase
    end
endmodule

// File: rtl/slp_clkgate_ctrl.sv
module slp_clkgate_ctrl
    import slp_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int LVL_HOLD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_en,
    input  logic             sleep_req,
    input  logic [2:0]       mode,
    input  logic             adc_en,
    input  logic             t0_async,
    input  logic             t0_irq_en,
    input  logic             gie,
    input  logic [7:0]       wake_req,
    input  logic [CNT_W-1:0] startup_cnt,
    output logic             cpu_clk_en,
    output logic             flash_clk_en,
    output logic             io_clk_en,
    output logic             adc_clk_en,
    output logic             asy_clk_en,
    output logic             osc_stop,
    output logic             adc_start,
    output logic [2:0]       state_o
);
    slp_state_e state_q, state_d;
    logic       wake_hit;
    logic       tmr_done;
    logic       deep;
    logic       keep_asy;
    logic       accept;
    clk_ctl_t   ctl;

    assign deep   = (state_q == ST_PDOWN) || (state_q == ST_PSAVE);
    assign accept = (state_q == ST_RUN) && sleep_req && sleep_en;

    slp_wake_mask #(.LVL_HOLD(LVL_HOLD)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state_q),
        .wake_req  (wake_req),
        .t0_async  (t0_async),
        .t0_irq_en (t0_irq_en),
        .gie       (gie),
        .wake_hit  (wake_hit)
    );

    slp_start_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (deep && wake_hit),
        .load_val (startup_cnt),
        .active   (state_q == ST_START),
        .done     (tmr_done)
    );

    slp_clk_decode u_dec (
        .state    (state_q),
        .keep_asy (keep_asy),
        .ctl      (ctl)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (accept) begin
                    unique case (mode)
                        MD_IDLE:  state_d = ST_IDLE;
                        MD_ADCNR: state_d = ST_ADCNR;
                        MD_PDOWN: state_d = ST_PDOWN;
                        MD_PSAVE: state_d = ST_PSAVE;
                        default:  state_d = ST_RUN;
                    endcase
                end
            end
            ST_IDLE, ST_ADCNR: if (wake_hit) state_d = ST_RUN;
            ST_PDOWN, ST_PSAVE: if (wake_hit) state_d = ST_START;
            ST_START: if (tmr_done) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // Registered side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_start <= 1'b0;
            keep_asy  <= 1'b0;
        end else begin
            adc_start <= accept && (mode[2:1] == 2'b00) && adc_en;
            if (deep && wake_hit) keep_asy <= (state_q == ST_PSAVE);
        end
    end

    assign cpu_clk_en   = ctl.cpu;
    assign flash_clk_en = ctl.flash;
    assign io_clk_en    = ctl.io;
    assign adc_clk_en   = ctl.adc;
    assign asy_clk_en   = ctl.asy;
    assign osc_stop     = ctl.osc_stop;
    assign state_o      = state_q;
endmodule

// File: rtl/slp_clkgate_ctrl_chk.sv
module slp_clkgate_ctrl_chk
    import slp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_en,
    input logic       sleep_req,
    input logic [2:0] mode,
    input logic [7:0] wake_req,
    input logic [2:0] state_o,
    input logic       cpu_clk_en,
    input logic       flash_clk_en,
    input logic       io_clk_en,
    input logic       adc_clk_en,
    input logic       asy_clk_en,
    input logic       osc_stop,
    input logic       adc_start
);
    AST_ADC_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R11
    AST_ADC_PULSE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (state_o == ST_IDLE || state_o == ST_ADCNR)); // R11
    AST_OSC_STOP_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        osc_stop |-> (state_o == ST_PDOWN || state_o == ST_PSAVE)); // R4
    AST_CORE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != ST_RUN) |-> (!cpu_clk_en && !flash_clk_en)); // R4
    AST_PDOWN_ASY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PDOWN) |-> !asy_clk_en); // R4
    AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RUN && sleep_req && mode[2]) |=> (state_o == ST_RUN)); // R3
    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_RUN && !sleep_en) |=> (state_o == ST_RUN)); // R3
    AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE && (|wake_req)) |=> (state_o == ST_RUN)); // R5
    AST_PDOWN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_PDOWN) |=> (state_o == ST_PDOWN || state_o == ST_START)); // R7
    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_START) |-> (!io_clk_en && !adc_clk_en && !osc_stop)); // R10
endmodule

bind slp_clkgate_ctrl slp_clkgate_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_en     (sleep_en),
    .sleep_req    (sleep_req),
    .mode         (mode),
    .wake_req     (wake_req),
    .state_o      (state_o),
    .cpu_clk_en   (cpu_clk_en),
    .flash_clk_en (flash_clk_en),
    .io_clk_en    (io_clk_en),
    .adc_clk_en   (adc_clk_en),
    .asy_clk_en   (asy_clk_en),
    .osc_stop     (osc_stop),
    .adc_start    (adc_start)
);

// File: tb/slp_clkgate_ctrl_tb_top.sv
module slp_clkgate_ctrl_tb_top;
    localparam int CNT_W    = 8;
    localparam int LVL_HOLD = 4;
    localparam int S_RUN = 0, S_IDLE = 1, S_ADCNR = 2, S_PDOWN = 3, S_PSAVE = 4, S_START = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_en = 0, sleep_req = 0, adc_en = 0, t0_async = 0, t0_irq_en = 0, gie = 0;
    logic [2:0] mode = 0;
    logic [7:0] wake_req = 0;
    logic [CNT_W-1:0] startup_cnt = 0;
    logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, asy_clk_en, osc_stop, adc_start;
    logic [2:0] state_o;

    // Stimulus staged by the bench, applied on the falling edge
    logic i_sen = 0, i_req = 0, i_adc = 0, i_t0a = 0, i_t0e = 0, i_gie = 0;
    logic [2:0] i_mode = 0;
    logic [7:0] i_wake = 0;
    logic [CNT_W-1:0] i_cnt = 0;

    // Reference model state
    int m_state = S_RUN;
    int m_cnt = 0;
    int m_lvl = 0;
    bit m_keep = 0;
    bit m_adc = 0;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    slp_clkgate_ctrl #(.CNT_W(CNT_W), .LVL_HOLD(LVL_HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .sleep_req(sleep_req), .mode(mode),
        .adc_en(adc_en), .t0_async(t0_async), .t0_irq_en(t0_irq_en), .gie(gie),
        .wake_req(wake_req), .startup_cnt(startup_cnt), .cpu_clk_en(cpu_clk_en),
        .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
        .asy_clk_en(asy_clk_en), .osc_stop(osc_stop), .adc_start(adc_start), .state_o(state_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // {cpu, flash, io, adc, asy, osc_stop} expected in each state
    function automatic logic [5:0] exp_ctl(input int st, input bit keep);
        case (st)
            S_RUN:   return 6'b111110;
            S_IDLE:  return 6'b001110;
            S_ADCNR: return 6'b000110;
            S_PDOWN: return 6'b000001;
            S_PSAVE: return 6'b000011;
            default: return {4'b0000, keep, 1'b0};
        endcase
    endfunction

    function automatic logic [7:0] exp_mask(input int st, input bit t0ok);
        case (st)
            S_IDLE:  return 8'hFF;
            S_ADCNR: return 8'hFE;
            S_PDOWN: return 8'h1E;
            S_PSAVE: return t0ok ? 8'h5E : 8'h1E;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        bit deep, lvl_ok, hit;
        logic [7:0] q;
        int nst;
        deep   = (m_state == S_PDOWN) || (m_state == S_PSAVE);
        lvl_ok = i_wake[4] && (m_lvl >= LVL_HOLD - 1);
        q = i_wake;
        if (deep) q[4] = lvl_ok;
        hit = |(q & exp_mask(m_state, i_t0a && i_t0e && i_gie));
        m_adc = (m_state == S_RUN) && i_req && i_sen && (i_mode <= 3'd1) && i_adc;
        nst = m_state;
        case (m_state)
            S_RUN: if (i_req && i_sen && i_mode <= 3'd3) nst = S_IDLE + int'(i_mode);
            S_IDLE, S_ADCNR: if (hit) nst = S_RUN;
            S_PDOWN, S_PSAVE: if (hit) begin
                nst = S_START;
                m_keep = (m_state == S_PSAVE);
                m_cnt = int'(i_cnt);
            end
            default: begin
                if (m_cnt == 0) nst = S_RUN;
                else m_cnt--;
            end
        endcase
        if (deep && i_wake[4]) begin
            if (m_lvl < LVL_HOLD - 1) m_lvl++;
        end else begin
            m_lvl = 0;
        end
        m_state = nst;
    endtask

    // One cycle: compare on the falling edge, drive new inputs, advance the model
    task automatic cyc();
        @(negedge clk);
        chk(int'(state_o) == m_state, "R2 state", int'(state_o), m_state);
        chk({cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, asy_clk_en, osc_stop} == exp_ctl(m_state, m_keep),
            "R4 clock enables", int'({cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, asy_clk_en, osc_stop}),
            int'(exp_ctl(m_state, m_keep)));
        chk(adc_start == m_adc, "R11 adc_start", int'(adc_start), int'(m_adc));
        sleep_en = i_sen; sleep_req = i_req; mode = i_mode; adc_en = i_adc;
        t0_async = i_t0a; t0_irq_en = i_t0e; gie = i_gie; wake_req = i_wake; startup_cnt = i_cnt;
        model_step();
    endtask

    // Sample just after the rising edge that follows the last drive
    task automatic expect_state(input int exp, input string tag);
        @(posedge clk);
        #2;
        chk(int'(state_o) == exp, tag, int'(state_o), exp);
    endtask

    task automatic clear_in();
        i_req = 0; i_wake = 0;
    endtask

    task automatic enter(input logic [2:0] md);
        i_sen = 1; i_req = 1; i_mode = md; i_wake = 0;
        cyc();
        i_req = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        // R1: outputs held at their reset values
        chk(state_o == 3'd0, "R1 reset state", int'(state_o), 0);
        chk({cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, asy_clk_en, osc_stop, adc_start} == 7'b1111100,
            "R1 reset outputs", int'({cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, asy_clk_en, osc_stop, adc_start}),
            int'(7'b1111100));
        rst_n = 1'b1;
        cyc();

        // R3: sleep disabled, then a reserved mode code
        i_sen = 0; i_req = 1; i_mode = 3'd0; cyc(); expect_state(S_RUN, "R3 sleep_en low");
        i_sen = 1; i_req = 1; i_mode = 3'd5; cyc(); expect_state(S_RUN, "R3 reserved mode");
        clear_in(); cyc();

        // R2 and R11: Idle with the ADC enabled, then R5: wake on bit 0
        i_adc = 1; enter(3'd0);
        @(posedge clk); #2;
        chk(state_o == 3'd1, "R2 enter IDLE", int'(state_o), S_IDLE);
        chk(adc_start == 1'b1, "R11 pulse on IDLE entry", int'(adc_start), 1);
        cyc();
        i_wake = 8'h01; cyc(); expect_state(S_RUN, "R5 IDLE wake on bit 0");
        clear_in(); cyc();

        // R6: ADCNR ignores bit 0, wakes on ADC done (bit 5)
        enter(3'd1);
        i_wake = 8'h01; cyc(); cyc(); expect_state(S_ADCNR, "R6 bit 0 ignored");
        i_wake = 8'h20; cyc(); expect_state(S_RUN, "R6 wake on bit 5");
        clear_in(); i_adc = 0; cyc();

        // R7 and R9: PDOWN with start-up count 3
        i_cnt = 8'd3; enter(3'd2);
        i_wake = 8'hE1; cyc(); cyc(); expect_state(S_PDOWN, "R7 bits 0,5,6,7 ignored");
        i_wake = 8'h10; cyc(); cyc(); cyc(); i_wake = 8'h00; cyc(); expect_state(S_PDOWN, "R9 short level pulse ignored");
        i_wake = 8'h10; cyc(); cyc(); cyc(); expect_state(S_PDOWN, "R9 third cycle not yet");
        cyc(); expect_state(S_START, "R9 level wake on fourth cycle");
        i_wake = 8'h00;
        for (int k = 0; k < 3; k++) begin
            cyc(); expect_state(S_START, "R10 START held");
        end
        cyc(); expect_state(S_RUN, "R10 RUN after startup_cnt+1");
        cyc();

        // R8: PSAVE timer wake needs all three qualifiers
        i_cnt = 8'd1; enter(3'd3);
        i_t0a = 1; i_t0e = 1; i_gie = 0; i_wake = 8'h40; cyc(); cyc(); expect_state(S_PSAVE, "R8 timer wake blocked");
        i_gie = 1; cyc(); expect_state(S_START, "R8 timer wake accepted");
        #1;
        chk(asy_clk_en == 1'b1, "R10 asy kept in START from PSAVE", int'(asy_clk_en), 1);
        clear_in(); cyc(); cyc(); expect_state(S_RUN, "R10 short start-up");
        cyc();

        // R7: address match from PDOWN, start-up count 0
        i_cnt = 8'd0; enter(3'd2);
        i_wake = 8'h04; cyc(); expect_state(S_START, "R7 address match wakes");
        clear_in(); cyc(); expect_state(S_RUN, "R10 zero start-up");

        // Constrained random traffic against the model
        begin
            bit lvl_hold = 0;
            for (int n = 0; n < 4000; n++) begin
                i_req  = ($urandom % 16) == 0;
                i_sen  = ($urandom % 5) != 0;
                i_mode = 3'($urandom % 8);
                i_adc  = $urandom % 2;
                i_t0a  = ($urandom % 3) != 0;
                i_t0e  = ($urandom % 3) != 0;
                i_gie  = ($urandom % 3) != 0;
                i_cnt  = CNT_W'($urandom % 6);
                if (($urandom % 7) == 0) lvl_hold = ~lvl_hold;
                i_wake = (($urandom % 10) == 0) ? (8'h01 << ($urandom % 8)) : 8'h00;
                i_wake[4] = i_wake[4] | lvl_hold;
                cyc();
            end
        end
        clear_in();
        cyc();

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule